// File: doc/BRIEF.md
# I2C Slave Address-Match Controller

This block is the target side of an I2C-compatible byte controller. It watches the two open-drain bus lines. Each line is modelled as a sampled input plus an active-high "pull low" enable. After every START the block collects the first byte and compares its upper seven bits with a programmable own address. On a match it acknowledges without help from software, records the direction the master asked for, and raises a byte interrupt.

After that, every 9-bit unit (eight data bits and an acknowledge) ends with the interrupt flag set and SCL held low. The clock stays held until software touches the data register. A write sends the next byte when the block is in transmit mode. A read picks up the received byte and starts the next one when the block is in receive mode. The first read after the address is only a dummy read that lets the clock go. When the master answers a transmitted byte with NACK, software switches to receive mode and does a dummy read. This frees both lines for the master's STOP. A STOP or a repeated START always returns the block to address comparison.

Software uses a small register port with four offsets:
- 0: own address.
- 1: control. Bit 0 selects transmit mode. Bit 1 set suppresses the acknowledge.
- 2: status. Bit 0 is the received ninth-bit level, bit 1 is the byte flag, bit 2 is the captured direction and bit 3 is addressed-as-slave.
- 3: data.

Top module: `i2cs_addr_match`

## Requirements
- R1: After reset both line enables are low, the interrupt is low and the status register (offset 2) reads 0.
- R2: When the first byte after START has bits 7:1 equal to the own-address register (offset 0, bits 6:0) and control bit 1 is 0, the block pulls SDA low during the ninth clock.
- R3: An address byte that does not match gets no acknowledge and raises no flag. Following bytes are ignored until the next START, and SCL is never held.
- R4: At the end of every acknowledged or transmitted 9-bit unit, status bit 1 and the interrupt output go high. SCL stays held low until software reads or writes the data register (offset 3) in the matching mode.
- R5: Status bit 2 holds bit 0 of the matching address byte (1 means the slave transmits). Status bit 3 is 1 after an address unit and 0 after a data unit.
- R6: Any write to the status register clears the byte flag and the interrupt.
- R7: In receive mode (control bit 0 = 0), a data-register read releases SCL. The next byte is then shifted in MSB first, acknowledged, and read back from offset 3.
- R8: With control bit 1 = 1, a received data byte is not acknowledged, but it is still stored and flagged.
- R9: In transmit mode (control bit 0 = 1), a data-register write sends that byte MSB first. The level the master drives in the ninth clock is stored in status bit 0 (1 = NACK).
- R10: After a NACK, switching to receive mode and doing a dummy data read releases both SDA and SCL. The STOP that follows brings the block back to idle, ready for a new address.
- R11: A STOP or a repeated START clears status bit 3, releases SDA and restarts address comparison.
- R12: The SDA enable changes only after SCL has been low for at least HOLD_CYC system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| sclOe | output | 1 | Pull SCL low (clock stretch) |
| sdaOe | output | 1 | Pull SDA low |
| regAddr | input | 2 | Register offset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data, combinational from regAddr |
| intr | output | 1 | Byte-complete interrupt |

## Verification
The address compare is driven with a matching write address, a matching read address sent after a repeated START, and an address that does not match. These three cases show acknowledge-and-flag behaviour against silent ignore, and show that the captured direction bit follows the address LSB.

Received bytes with alternating bit patterns and asymmetric bit patterns would show any bit-order or shift error. The same receive path is run with the acknowledge suppressed and with it enabled.

Transmitted bytes are ended once with ACK and once with NACK, which checks the captured ninth bit. The NACK case also checks the release sequence that lets the master's STOP through.

The SCL enable is checked before and after software accesses, to separate stretching from release. A bench monitor watches the hold gap between each SCL fall and any change on SDA.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int ByteW = 8;
  localparam int OwnW  = 7;

  localparam logic [1:0] OFS_OWN  = 2'd0;
  localparam logic [1:0] OFS_CTRL = 2'd1;
  localparam logic [1:0] OFS_STAT = 2'd2;
  localparam logic [1:0] OFS_DATA = 2'd3;

  // strobes from the sequencer into the datapath
  typedef struct packed {
    logic shiftIn;    // sample SDA into the shifter
    logic shiftOut;   // advance the transmit shifter
    logic loadTx;     // load shifter from register write data
    logic captureRx;  // copy shifter into receive holding register
    logic latchAck;   // store ninth-bit level seen from the master
    logic unitDone;   // a 9-bit unit finished: raise flag
    logic addrUnit;   // the finished unit carried the address
    logic dropAddr;   // START/STOP: clear addressed bit
  } strobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ACK, S_RX, S_TX, S_TXACK, S_WAIT, S_SKIP
  } state_t;

endpackage

// File: rtl/i2cs_dp.sv
module i2cs_dp
  import i2cs_pkg::*;
#(
  parameter int SYNC_LEN = 2,
  parameter int HOLD_CYC = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [1:0]       regAddr,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [ByteW-1:0] regWdata,
  output logic [ByteW-1:0] regRdata,
  input  strobe_t          stb,
  output logic             sclRise,
  output logic             fallAct,
  output logic             startSeen,
  output logic             stopSeen,
  output logic             addrHit,
  output logic             shiftMsb,
  output logic             txMode,
  output logic             noAck,
  output logic             dataWr,
  output logic             dataRd,
  output logic             intr
);

  localparam int HoldW = $clog2(HOLD_CYC + 1);

  // ---------------- line synchronisers ----------------
  logic [SYNC_LEN-1:0] sclSync, sdaSync;

  genvar g;
  generate
    for (g = 0; g < SYNC_LEN; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) begin
            sclSync[0] <= 1'b1;
            sdaSync[0] <= 1'b1;
          end else begin
            sclSync[0] <= sclIn;
            sdaSync[0] <= sdaIn;
          end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) begin
            sclSync[g] <= 1'b1;
            sdaSync[g] <= 1'b1;
          end else begin
            sclSync[g] <= sclSync[g-1];
            sdaSync[g] <= sdaSync[g-1];
          end
      end
    end
  endgenerate

  logic sclNow, sdaNow, sclPrev, sdaPrev;
  assign sclNow = sclSync[SYNC_LEN-1];
  assign sdaNow = sdaSync[SYNC_LEN-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end

  logic sclFall;
  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  assign startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  // ---------------- post-fall hold delay ----------------
  logic [HoldW-1:0] holdCnt;
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                holdCnt <= '0;
    else if (sclFall)         holdCnt <= HoldW'(HOLD_CYC);
    else if (holdCnt != '0)   holdCnt <= holdCnt - 1'b1;

  assign fallAct = (holdCnt == HoldW'(1));

  // ---------------- registers ----------------
  logic [OwnW-1:0]  ownAddr;
  logic [ByteW-1:0] shiftReg, rxData;
  logic             flag, srw, addressed, rxNack;
  logic             statWr;

  assign dataWr = regWrEn && (regAddr == OFS_DATA);
  assign dataRd = regRdEn && (regAddr == OFS_DATA);
  assign statWr = regWrEn && (regAddr == OFS_STAT);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      ownAddr <= '0;
      txMode  <= 1'b0;
      noAck   <= 1'b0;
    end else if (regWrEn) begin
      if (regAddr == OFS_OWN) ownAddr <= regWdata[OwnW-1:0];
      if (regAddr == OFS_CTRL) begin
        txMode <= regWdata[0];
        noAck  <= regWdata[1];
      end
    end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)              shiftReg <= '0;
    else if (stb.loadTx)    shiftReg <= regWdata;
    else if (stb.shiftIn)   shiftReg <= {shiftReg[ByteW-2:0], sdaNow};
    else if (stb.shiftOut)  shiftReg <= {shiftReg[ByteW-2:0], 1'b1};

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      rxData    <= '0;
      flag      <= 1'b0;
      srw       <= 1'b0;
      addressed <= 1'b0;
      rxNack    <= 1'b0;
    end else begin
      if (stb.captureRx) rxData <= shiftReg;
      if (stb.latchAck)  rxNack <= sdaNow;
      if (stb.unitDone)  flag <= 1'b1;
      else if (statWr)   flag <= 1'b0;
      if (stb.unitDone && stb.addrUnit) srw <= shiftReg[0];
      if (stb.dropAddr)      addressed <= 1'b0;
      else if (stb.unitDone) addressed <= stb.addrUnit;
    end

  assign addrHit  = (shiftReg[ByteW-1:1] == ownAddr);
  assign shiftMsb = shiftReg[ByteW-1];
  assign intr     = flag;

  always_comb begin
    unique case (regAddr)
      OFS_OWN:  regRdata = {1'b0, ownAddr};
      OFS_CTRL: regRdata = {6'b0, noAck, txMode};
      OFS_STAT: regRdata = {4'b0, addressed, srw, flag, rxNack};
      default:  regRdata = rxData;
    endcase
  end

endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclRise,
  input  logic    fallAct,
  input  logic    startSeen,
  input  logic    stopSeen,
  input  logic    addrHit,
  input  logic    shiftMsb,
  input  logic    txMode,
  input  logic    noAck,
  input  logic    dataWr,
  input  logic    dataRd,
  output strobe_t stb,
  output logic    sclOe,
  output logic    sdaOe
);

  state_t     state, nState;
  logic [3:0] bitCnt, nBitCnt;
  logic       ninthSeen, nNinth;
  logic       ackOn, nAckOn;
  logic       isAddr, nIsAddr;

  always_comb begin
    stb     = '0;
    nState  = state;
    nBitCnt = bitCnt;
    nNinth  = ninthSeen;
    nAckOn  = ackOn;
    nIsAddr = isAddr;

    if (startSeen) begin
      nState       = S_ADDR;
      nBitCnt      = '0;
      stb.dropAddr = 1'b1;
    end else if (stopSeen) begin
      nState       = S_IDLE;
      stb.dropAddr = 1'b1;
    end else begin
      unique case (state)
        S_ADDR, S_RX: begin
          if (sclRise) begin
            stb.shiftIn = 1'b1;
            nBitCnt     = bitCnt + 1'b1;
          end
          if (fallAct && bitCnt == 4'd8) begin
            nNinth = 1'b0;
            nAckOn = ~noAck;
            if (state == S_RX) begin
              stb.captureRx = 1'b1;
              nIsAddr       = 1'b0;
              nState        = S_ACK;
            end else if (addrHit) begin
              nIsAddr = 1'b1;
              nState  = S_ACK;
            end else begin
              nState = S_SKIP;
            end
          end
        end
        S_ACK: begin
          if (sclRise) nNinth = 1'b1;
          if (fallAct && ninthSeen) begin
            stb.unitDone = 1'b1;
            stb.addrUnit = isAddr;
            nState       = S_WAIT;
          end
        end
        S_WAIT: begin
          if (txMode && dataWr) begin
            stb.loadTx = 1'b1;
            nBitCnt    = '0;
            nState     = S_TX;
          end else if (!txMode && dataRd) begin
            nBitCnt = '0;
            nState  = S_RX;
          end
        end
        S_TX: begin
          if (sclRise) nBitCnt = bitCnt + 1'b1;
          if (fallAct && bitCnt != '0) begin
            if (bitCnt == 4'd8) begin
              nNinth = 1'b0;
              nState = S_TXACK;
            end else begin
              stb.shiftOut = 1'b1;
            end
          end
        end
        S_TXACK: begin
          if (sclRise) begin
            stb.latchAck = 1'b1;
            nNinth       = 1'b1;
          end
          if (fallAct && ninthSeen) begin
            stb.unitDone = 1'b1;
            nState       = S_WAIT;
          end
        end
        default: ;  // idle and skip wait for START
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      state     <= S_IDLE;
      bitCnt    <= '0;
      ninthSeen <= 1'b0;
      ackOn     <= 1'b0;
      isAddr    <= 1'b0;
    end else begin
      state     <= nState;
      bitCnt    <= nBitCnt;
      ninthSeen <= nNinth;
      ackOn     <= nAckOn;
      isAddr    <= nIsAddr;
    end

  assign sclOe = (state == S_WAIT);
  assign sdaOe = ((state == S_ACK) && ackOn) || ((state == S_TX) && !shiftMsb);

endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match
  import i2cs_pkg::*;
#(
  parameter int SYNC_LEN = 2,
  parameter int HOLD_CYC = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe,
  input  logic [1:0] regAddr,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       intr
);

  strobe_t stb;
  logic sclRise, fallAct, startSeen, stopSeen, addrHit, shiftMsb;
  logic txMode, noAck, dataWr, dataRd;

  i2cs_dp #(.SYNC_LEN(SYNC_LEN), .HOLD_CYC(HOLD_CYC)) dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWdata(regWdata), .regRdata(regRdata), .stb(stb),
    .sclRise(sclRise), .fallAct(fallAct), .startSeen(startSeen),
    .stopSeen(stopSeen), .addrHit(addrHit), .shiftMsb(shiftMsb),
    .txMode(txMode), .noAck(noAck), .dataWr(dataWr), .dataRd(dataRd),
    .intr(intr)
  );

  i2cs_ctrl ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .fallAct(fallAct),
    .startSeen(startSeen), .stopSeen(stopSeen), .addrHit(addrHit),
    .shiftMsb(shiftMsb), .txMode(txMode), .noAck(noAck),
    .dataWr(dataWr), .dataRd(dataRd), .stb(stb),
    .sclOe(sclOe), .sdaOe(sdaOe)
  );

endmodule

// File: rtl/i2cs_addr_match_chk.sv
module i2cs_addr_match_chk #(
  parameter int HOLD_CYC = 3
) (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sclOe,
  input logic       sdaOe,
  input logic [1:0] regAddr,
  input logic       regWrEn,
  input logic       regRdEn,
  input logic [7:0] regRdata,
  input logic       intr
);

  logic [7:0] lowCnt;
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                 lowCnt <= '0;
    else if (sclIn)            lowCnt <= '0;
    else if (lowCnt != 8'hFF)  lowCnt <= lowCnt + 1'b1;

  // R12: SDA enable moves only after SCL has been low for the hold time
  a_r12_sda_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> (int'(lowCnt) >= HOLD_CYC));

  // R4: stretching only grabs a clock that is already low
  a_r4_grab_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclOe) |-> !sclIn);

  // R4: the clock is let go only after a data-register access
  a_r4_release_on_access: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclOe) |-> $past((regRdEn || regWrEn) && regAddr == 2'd3));

  // R4: interrupt output mirrors status bit 1
  a_r4_intr_status: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd2) |-> (regRdata[1] == intr));

  // R6: a status write clears the flag unless a new unit ends at once
  a_r6_clear: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd2) |=> (!intr || sclOe));

endmodule

bind i2cs_addr_match i2cs_addr_match_chk #(.HOLD_CYC(HOLD_CYC)) chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sclOe(sclOe), .sdaOe(sdaOe),
  .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regRdata(regRdata), .intr(intr)
);

// File: tb/i2cs_addr_match_test.sv
module i2cs_addr_match_test;

  localparam int HOLD = 3;
  localparam int Q = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic mScl = 1'b1, mSda = 1'b1;
  logic sclOe, sdaOe, intr;
  logic [1:0] regAddr = 2'd0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0] regWdata = 8'h00, regRdata;
  logic sclLine, sdaLine;

  assign sclLine = mScl & ~sclOe;
  assign sdaLine = mSda & ~sdaOe;

  i2cs_addr_match #(.SYNC_LEN(2), .HOLD_CYC(HOLD)) uut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclOe(sclOe), .sdaOe(sdaOe), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWdata(regWdata), .regRdata(regRdata), .intr(intr)
  );

  int total = 0, bad = 0;
  logic [7:0] expQ[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pushExp(input logic [7:0] b);
    expQ.push_back(b);
  endtask

  // monitor side of the scoreboard: compare a produced byte with the oldest expectation
  task automatic popCheck(input string req, input logic [7:0] act);
    logic [7:0] e;
    if (expQ.size() == 0) begin
      chk(1'b0, req, act, 0);
    end else begin
      e = expQ.pop_front();
      chk(act == e, req, act, e);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic mBit(input logic b, output logic r);
    mSda = b; waitClk(Q);
    mScl = 1'b1;
    while (!sclLine) @(negedge clk);
    waitClk(Q);
    r = sdaLine;
    waitClk(Q);
    mScl = 1'b0; waitClk(Q);
  endtask

  task automatic mStart;
    mSda = 1'b1; waitClk(Q);
    mScl = 1'b1;
    while (!sclLine) @(negedge clk);
    waitClk(Q);
    mSda = 1'b0; waitClk(Q);
    mScl = 1'b0; waitClk(Q);
  endtask

  task automatic mStop;
    mSda = 1'b0; waitClk(Q);
    mScl = 1'b1;
    while (!sclLine) @(negedge clk);
    waitClk(Q);
    mSda = 1'b1; waitClk(Q);
  endtask

  task automatic mByte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) mBit(d[i], r);
    mBit(1'b1, ack);
  endtask

  task automatic mReadByte(input logic ackBit, output logic [7:0] d);
    logic r;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      mBit(1'b1, r);
      d = {d[6:0], r};
    end
    mBit(ackBit, r);
  endtask

  // hold-time monitor for R12
  int lowRun = 0, r12Bad = 0;
  logic prevSdaOe = 1'b0;
  always @(negedge clk) begin
    if (rstN && (sdaOe !== prevSdaOe) && lowRun < HOLD) r12Bad++;
    prevSdaOe <= sdaOe;
    lowRun <= sclLine ? 0 : lowRun + 1;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] st, d;
    logic ack;
    waitClk(10);
    rstN = 1'b1;
    waitClk(2);

    // R1 reset state
    chk(sclOe == 1'b0 && sdaOe == 1'b0, "R1 lines", {sclOe, sdaOe}, 0);
    chk(intr == 1'b0, "R1 intr", intr, 0);
    regRead(2'd2, st);
    chk(st == 8'h00, "R1 status", st, 0);

    regWrite(2'd0, 8'h33);
    regWrite(2'd1, 8'h00);

    // write transaction to own address
    mStart;
    mByte(8'h66, ack);
    chk(ack == 1'b0, "R2 address ack", ack, 0);
    chk(intr == 1'b1, "R4 flag after address", intr, 1);
    chk(sclOe == 1'b1, "R4 stretch after address", sclOe, 1);
    regRead(2'd2, st);
    chk(st == 8'h0A, "R5 status after write address", st, 8'h0A);
    regWrite(2'd2, 8'h00);
    chk(intr == 1'b0, "R6 flag cleared", intr, 0);
    chk(sclOe == 1'b1, "R4 still stretched", sclOe, 1);
    regRead(2'd3, d);  // dummy read
    waitClk(2);
    chk(sclOe == 1'b0, "R7 dummy read releases", sclOe, 0);

    pushExp(8'hA5);
    mByte(8'hA5, ack);
    chk(ack == 1'b0, "R7 data ack", ack, 0);
    regRead(2'd2, st);
    chk(st == 8'h02, "R5 status after data", st, 8'h02);
    regWrite(2'd2, 8'h00);
    regRead(2'd3, d);
    popCheck("R7 received A5", d);

    pushExp(8'h3C);
    mByte(8'h3C, ack);
    chk(ack == 1'b0, "R7 data ack 2", ack, 0);
    regWrite(2'd2, 8'h00);
    regRead(2'd3, d);
    popCheck("R7 received 3C", d);

    // R8 acknowledge suppressed
    regWrite(2'd1, 8'h02);
    pushExp(8'h81);
    mByte(8'h81, ack);
    chk(ack == 1'b1, "R8 no ack", ack, 1);
    chk(intr == 1'b1, "R8 still flagged", intr, 1);
    regWrite(2'd2, 8'h00);
    regWrite(2'd1, 8'h00);
    regRead(2'd3, d);
    popCheck("R8 received 81", d);

    // R11 repeated start with read direction
    mStart;
    mByte(8'h67, ack);
    chk(ack == 1'b0, "R11 restart address ack", ack, 0);
    regRead(2'd2, st);
    chk(st == 8'h0E, "R5 read direction captured", st, 8'h0E);
    regWrite(2'd2, 8'h00);

    // R9 transmit
    regWrite(2'd1, 8'h01);
    pushExp(8'hC3);
    regWrite(2'd3, 8'hC3);
    waitClk(2);
    chk(sclOe == 1'b0, "R9 write releases", sclOe, 0);
    mReadByte(1'b0, d);
    popCheck("R9 sent C3", d);
    regRead(2'd2, st);
    chk(st == 8'h06, "R9 ack captured", st, 8'h06);
    regWrite(2'd2, 8'h00);
    pushExp(8'h5A);
    regWrite(2'd3, 8'h5A);
    mReadByte(1'b1, d);
    popCheck("R9 sent 5A", d);
    regRead(2'd2, st);
    chk(st == 8'h07, "R9 nack captured", st, 8'h07);
    regWrite(2'd2, 8'h00);

    // R10 release after NACK
    chk(sclOe == 1'b1, "R10 held before release", sclOe, 1);
    regWrite(2'd1, 8'h00);
    regRead(2'd3, d);
    waitClk(2);
    chk(sclOe == 1'b0 && sdaOe == 1'b0, "R10 lines free", {sclOe, sdaOe}, 0);
    mStop;
    waitClk(8);
    mStart;
    mByte(8'h66, ack);
    chk(ack == 1'b0, "R10 new address after stop", ack, 0);

    // R11 stop clears addressed bit
    regWrite(2'd2, 8'h00);
    regRead(2'd3, d);
    mStop;
    waitClk(8);
    regRead(2'd2, st);
    chk(st[3] == 1'b0, "R11 addressed cleared by stop", st[3], 0);
    chk(sdaOe == 1'b0, "R11 sda released", sdaOe, 0);

    // R3 mismatch
    mStart;
    mByte(8'h40, ack);
    chk(ack == 1'b1, "R3 no ack on mismatch", ack, 1);
    chk(intr == 1'b0 && sclOe == 1'b0, "R3 no flag no stretch", {intr, sclOe}, 0);
    mByte(8'h00, ack);
    chk(ack == 1'b1, "R3 data ignored", ack, 1);
    chk(intr == 1'b0, "R3 still no flag", intr, 0);
    mStop;
    waitClk(8);

    chk(r12Bad == 0, "R12 hold violations", r12Bad, 0);
    chk(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule